// File: doc/BRIEF.md
# Synchronous Answer-to-Reset Serializer

This block answers a host's reset pulse with a fixed 32-bit identification header on the serial data pin. The host holds chip select low and raises the reset line briefly. When reset falls, the block drives the first header bit. Each later bit appears after a falling edge of the host's serial clock. No START condition is needed.

The header is four bytes: 19h, then 55h, then AAh, then 55h. Each byte goes out least significant bit first. The block leaves the pin undriven in three cases:
- when chip select is released;
- when the pulse arrives while the write engine is busy;
- after the last bit has been sent.

The serial clock and reset lines come from off chip. They are brought into the system clock domain through flop synchronizers, and edges are detected on the synchronized copies.

Top module: `atr_serializer`

## Requirements
- R1: After reset pulses high and then falls while `cs_n` is low and `wr_busy` is low, `sda_oe` goes high and `sda_out` carries header bit b1 (bit 0 of 19h, which is 1). This happens within a few system clocks of the fall.
- R2: A reset pulse that rises while `wr_busy` is high produces no answer. `sda_oe` stays low through the pulse and through any following serial clock edges.
- R3: The 32 bits come out as bytes 19h, 55h, AAh, 55h in that order, each least significant bit first.
- R4: The presented bit changes only after a falling edge of `scl`. A rising edge and a high level of `scl` leave `sda_out` unchanged.
- R5: While `cs_n` is high, `sda_oe` is low. An answer aborted this way does not resume when `cs_n` returns low.
- R6: The falling `scl` edge after bit b32 drops `sda_oe`. Further `scl` edges produce no output until the next arming pulse.
- R7: A reset pulse given while `cs_n` is high does not arm the block.
- R8: After system reset `rst_n` is released, `sda_oe` is low.
- R9: A new arming pulse in the middle of an answer restarts it from bit b1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| cs_n | input | 1 | Chip select, active low |
| rst_pin | input | 1 | Host reset line, pulsed high to request the answer |
| scl | input | 1 | Host serial clock |
| wr_busy | input | 1 | High while a nonvolatile write cycle runs |
| sda_out | output | 1 | Serial data value, low when not driving |
| sda_oe | output | 1 | Output enable for the tri-state data pin |

## Verification
A wrong bit index shows up at the pin as a header that is shifted or out of order. The error appears in the first bit presented after reset falls, or one `scl` fall later. A wrong state shows up as `sda_oe` in the wrong level:
- high after chip select is released;
- high after a busy-suppressed pulse;
- high after the 32nd bit;
- low before the header is finished.

Every one of these cases can be seen within a few system clocks of the causing edge. The bench samples each bit after both the rising and the falling half of every `scl` pulse, so an advance on the wrong edge is caught at once.

// File: rtl/atr_serializer.sv
module atr_serializer #(
  parameter int HDR_BITS    = 32,
  parameter logic [HDR_BITS-1:0] HDR_WORD = 32'h55AA5519,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic rst_pin,
  input  logic scl,
  input  logic wr_busy,
  output logic sda_out,
  output logic sda_oe
);
  localparam int CNT_W = $clog2(HDR_BITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HDR_BITS - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_SEND} state_t;

  logic [SYNC_STAGES-1:0] rst_sh, scl_sh;
  logic rst_d, scl_d;
  state_t state;
  logic [CNT_W-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sh <= '0;
      scl_sh <= '0;
      rst_d  <= 1'b0;
      scl_d  <= 1'b0;
    end else begin
      rst_sh <= {rst_sh[SYNC_STAGES-2:0], rst_pin};
      scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl};
      rst_d  <= rst_sh[SYNC_STAGES-1];
      scl_d  <= scl_sh[SYNC_STAGES-1];
    end
  end

  wire rst_s    = rst_sh[SYNC_STAGES-1];
  wire scl_s    = scl_sh[SYNC_STAGES-1];
  wire rst_rise = rst_s & ~rst_d;
  wire rst_fall = ~rst_s & rst_d;
  wire scl_fall = ~scl_s & scl_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else if (cs_n) begin
      state <= ST_IDLE;
    end else if (rst_rise) begin
      state <= wr_busy ? ST_IDLE : ST_ARMED;
    end else begin
      case (state)
        ST_ARMED: if (rst_fall) begin
          state <= ST_SEND;
          idx   <= '0;
        end
        ST_SEND: if (scl_fall) begin
          if (idx == LAST) state <= ST_IDLE;
          else             idx   <= idx + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign sda_oe  = (state == ST_SEND);
  assign sda_out = sda_oe & HDR_WORD[idx];

  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !sda_oe); // R5
  AST_BUSY_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && rst_rise && wr_busy) |=> (state == ST_IDLE)); // R2
  AST_HOLD_NO_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe && !cs_n && !rst_rise && !scl_fall) |=> (sda_oe && $stable(sda_out))); // R4
  AST_LAST_BIT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe && !cs_n && !rst_rise && scl_fall && idx == LAST) |=> !sda_oe); // R6
  AST_START_AT_B1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ARMED && !cs_n && rst_fall) |=> (sda_oe && sda_out == HDR_WORD[0])); // R1
endmodule

// File: tb/tb_atr_serializer.sv
module tb_atr_serializer;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, rst_pin = 1'b0, scl = 1'b0, wr_busy = 1'b0;
  logic sda_out, sda_oe;
  int n_chk = 0, n_bad = 0;
  logic [7:0] hb [4] = '{8'h19, 8'h55, 8'hAA, 8'h55};

  atr_serializer dut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rst_pin(rst_pin),
                      .scl(scl), .wr_busy(wr_busy), .sda_out(sda_out), .sda_oe(sda_oe));

  always #10 clk = ~clk;

  task automatic waitc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  function automatic logic hbit(int k);
    return hb[k / 8][k % 8];
  endfunction

  task automatic arm();
    rst_pin = 1'b1; waitc(8);
    rst_pin = 1'b0; waitc(6);
  endtask

  task automatic scl_pulse();
    scl = 1'b1; waitc(6);
  endtask

  task automatic scl_low();
    scl = 1'b0; waitc(6);
  endtask

  task automatic t_reset();
    chk("R8 oe after reset", sda_oe, 1'b0);
  endtask

  task automatic t_full_header();
    cs_n = 1'b0; waitc(3);
    arm();
    chk("R1 oe after arm", sda_oe, 1'b1);
    chk("R1 first bit", sda_out, hbit(0));
    for (int k = 1; k < 32; k++) begin
      scl_pulse();
      chk("R4 stable while scl high", sda_out, hbit(k - 1));
      scl_low();
      chk("R3 header bit", sda_out, hbit(k));
      chk("R3 oe during header", sda_oe, 1'b1);
    end
    scl_pulse(); scl_low();
    chk("R6 oe after b32", sda_oe, 1'b0);
    scl_pulse(); scl_low();
    chk("R6 quiet after end", sda_oe, 1'b0);
  endtask

  task automatic t_abort();
    arm();
    for (int k = 0; k < 5; k++) begin scl_pulse(); scl_low(); end
    chk("R3 bit b6", sda_out, hbit(5));
    cs_n = 1'b1; waitc(3);
    chk("R5 oe on deselect", sda_oe, 1'b0);
    cs_n = 1'b0; waitc(3);
    scl_pulse(); scl_low();
    chk("R5 no resume", sda_oe, 1'b0);
  endtask

  task automatic t_busy();
    wr_busy = 1'b1;
    rst_pin = 1'b1; waitc(8);
    rst_pin = 1'b0; waitc(6);
    wr_busy = 1'b0;
    chk("R2 busy suppresses", sda_oe, 1'b0);
    scl_pulse(); scl_low();
    chk("R2 still quiet", sda_oe, 1'b0);
  endtask

  task automatic t_deselected_pulse();
    cs_n = 1'b1; waitc(2);
    arm();
    cs_n = 1'b0; waitc(6);
    chk("R7 no arm while deselected", sda_oe, 1'b0);
  endtask

  task automatic t_restart();
    arm();
    for (int k = 0; k < 10; k++) begin scl_pulse(); scl_low(); end
    chk("R9 mid bit", sda_out, hbit(10));
    arm();
    chk("R9 oe after rearm", sda_oe, 1'b1);
    chk("R9 restart at b1", sda_out, hbit(0));
    scl_pulse(); scl_low();
    chk("R9 second bit", sda_out, hbit(1));
  endtask

  initial begin
    waitc(3); rst_n = 1'b1; waitc(3);
    t_reset();
    t_full_header();
    t_abort();
    t_busy();
    t_deselected_pulse();
    t_restart();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule